// File: doc/BRIEF.md
# Receive FIFO Fill Controller

This block decides which received bytes reach a receive FIFO and routes a chosen status event onto each of two interrupt lines. A byte strobe with its data arrives from the receive path. The controller passes it to the FIFO write port only while filling is allowed, and never into a full FIFO. How filling is allowed depends on the data mode:

- **Continuous mode:** nothing is written.
- **Packet mode:** every byte is written.
- **Buffered mode:** filling is gated by a fill-active flag. That flag is armed either by a detected sync word (automatic method) or directly by software (manual method).

A byte that arrives at a full FIFO while filling is allowed raises a sticky overrun flag. Software clears that flag by writing 1 to it, and the same write flushes the FIFO.

Software reaches the controller through a small write/read port with two 8-bit registers:

- an interrupt-source register holding the two 2-bit selectors;
- a fill-control register holding the fill method, fill-active, overrun and two read-only FIFO status bits.

Reads are combinational from the selected register. The interrupt outputs are combinational selections of the live event inputs. The meaning of each selector code depends on the data mode.

Top module: `rx_fifo_fill_ctrl`

## Requirements
- R1: After reset, every register bit is 0 (fill method auto, fill-active 0, overrun 0, both selectors 00). The write enable and the flush are low.
- R2: Data mode is decoded as 00 = continuous, 01 = buffered, 1x = packet. In continuous mode `fifo_wr_en` and `irq1` stay low whatever the inputs do.
- R3: In buffered mode with fill method 0 and overrun 0, a `sync_det` pulse sets fill-active at the next edge. While fill-active is 1, each `byte_vld` drives `fifo_wr_en` high in the same cycle with `fifo_wr_data` equal to `byte_data`, unless `fifo_full` is 1.
- R4: With fill method 0, writing 1 to fill-control bit 1 clears fill-active at the next edge. This clear wins over a `sync_det` in the same cycle. A later sync arms filling again.
- R5: While the overrun flag is 1, a sync pulse does not set fill-active.
- R6: With fill method 1 (fill-control bit 0), a write to the fill-control register loads bit 1 into fill-active (1 starts filling, 0 stops it), and `sync_det` has no effect on fill-active.
- R7: A `byte_vld` that would be written (packet mode, or buffered mode with fill-active 1) while `fifo_full` is 1 sets the overrun flag at the next edge and does not raise `fifo_wr_en`.
- R8: Writing 1 to fill-control bit 2 pulses `fifo_flush` in the same cycle and clears overrun at the next edge. The clear wins over a same-cycle overrun event.
- R9: Read data for `reg_sel`=0 is {0000, irq1_sel[1:0], irq0_sel[1:0]}. For `reg_sel`=1 it is {000, not-empty, full, overrun, fill-active, fill method}, where not-empty reads 0 when `fifo_empty` is 1.
- R10: `irq0` follows `irq0_sel` by mode. Buffered: 00 low, 01 write enable, 10 not-empty, 11 sync. Packet: 00 payload-ready, 01 write enable, 10 not-empty, 11 sync, or address-match when `addr_filt_en` is 1. Continuous: 00 low, 01 sync, 10 RSSI, 11 sync.
- R11: `irq1` follows `irq1_sel` in buffered and packet modes: 01 FIFO full, 10 RSSI, 11 FIFO threshold. Code 00 is low in buffered mode and CRC-ok in packet mode.
- R12: In packet mode every `byte_vld` is written when the FIFO is not full, regardless of fill-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_mode | input | 2 | 00 continuous, 01 buffered, 1x packet |
| sync_det | input | 1 | Sync word detected strobe |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | DW | Received byte |
| fifo_full | input | 1 | FIFO full status |
| fifo_empty | input | 1 | FIFO empty status |
| fifo_thresh | input | 1 | FIFO threshold reached |
| rssi_evt | input | 1 | RSSI above threshold indication |
| payload_rdy | input | 1 | Payload ready indication |
| crc_ok | input | 1 | CRC good indication |
| addr_match | input | 1 | Address match indication |
| addr_filt_en | input | 1 | Address filtering enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 interrupt-source register, 1 fill-control register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data of selected register |
| fifo_wr_en | output | 1 | FIFO write enable |
| fifo_wr_data | output | DW | FIFO write data |
| fifo_flush | output | 1 | FIFO flush pulse |
| fill_active | output | 1 | Fill-active flag |
| overrun | output | 1 | Overrun flag |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
The assertions watch, on every cycle:

- that a write never reaches a full FIFO;
- that continuous mode stays quiet;
- the arming of fill-active by sync and its blocking by overrun;
- the priority of both write-1 clears;
- that fill-active holds in manual mode.

Only the bench's scenarios can show:

- the full selector-code table for both interrupt lines in every mode;
- the read-back layout;
- the rearm-after-clear sequence;
- the data pass-through in packet mode.

The bench's cycle model compares all outputs on every clock.

// File: rtl/rx_fifo_fill_ctrl.sv
module rx_fifo_fill_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    data_mode,
  input  logic          sync_det,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic          fifo_thresh,
  input  logic          rssi_evt,
  input  logic          payload_rdy,
  input  logic          crc_ok,
  input  logic          addr_match,
  input  logic          addr_filt_en,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          fifo_wr_en,
  output logic [DW-1:0] fifo_wr_data,
  output logic          fifo_flush,
  output logic          fill_active,
  output logic          overrun,
  output logic          irq0,
  output logic          irq1
);
  localparam logic [1:0] MODE_BUF = 2'b01;

  logic       fill_method;
  logic [1:0] irq0_sel, irq1_sel;

  wire is_buf   = data_mode == MODE_BUF;
  wire is_pkt   = data_mode[1];
  wire sel_wr   = reg_wr & ~reg_sel;
  wire ctl_wr   = reg_wr & reg_sel;
  wire fill_clr = ctl_wr & ~fill_method & reg_wdata[1];
  wire ovr_clr  = ctl_wr & reg_wdata[2];
  wire accept   = byte_vld & (is_pkt | (is_buf & fill_active));

  assign fifo_wr_en   = accept & ~fifo_full;
  assign fifo_wr_data = byte_data;
  assign fifo_flush   = ovr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_method <= 1'b0;
      fill_active <= 1'b0;
      overrun     <= 1'b0;
      irq0_sel    <= 2'b00;
      irq1_sel    <= 2'b00;
    end else begin
      if (sel_wr) begin
        irq0_sel <= reg_wdata[1:0];
        irq1_sel <= reg_wdata[3:2];
      end
      if (ctl_wr) fill_method <= reg_wdata[0];

      if (fill_method) begin
        if (ctl_wr) fill_active <= reg_wdata[1];
      end else if (fill_clr) begin
        fill_active <= 1'b0;
      end else if (sync_det && is_buf && !overrun) begin
        fill_active <= 1'b1;
      end

      if (ovr_clr) overrun <= 1'b0;
      else if (accept && fifo_full) overrun <= 1'b1;
    end
  end

  assign reg_rdata = reg_sel
    ? {3'b000, ~fifo_empty, fifo_full, overrun, fill_active, fill_method}
    : {4'b0000, irq1_sel, irq0_sel};

  always_comb begin
    irq0 = 1'b0;
    if (is_pkt) begin
      case (irq0_sel)
        2'b00: irq0 = payload_rdy;
        2'b01: irq0 = fifo_wr_en;
        2'b10: irq0 = ~fifo_empty;
        default: irq0 = addr_filt_en ? addr_match : sync_det;
      endcase
    end else if (is_buf) begin
      case (irq0_sel)
        2'b00: irq0 = 1'b0;
        2'b01: irq0 = fifo_wr_en;
        2'b10: irq0 = ~fifo_empty;
        default: irq0 = sync_det;
      endcase
    end else begin
      case (irq0_sel)
        2'b10: irq0 = rssi_evt;
        2'b00: irq0 = 1'b0;
        default: irq0 = sync_det;
      endcase
    end
  end

  always_comb begin
    case (irq1_sel)
      2'b00: irq1 = is_pkt & crc_ok;
      2'b01: irq1 = fifo_full;
      2'b10: irq1 = rssi_evt;
      default: irq1 = fifo_thresh;
    endcase
    if (data_mode == 2'b00) irq1 = 1'b0;
  end
endmodule

// File: rtl/rx_fifo_fill_ctrl_chk.sv
module rx_fifo_fill_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] data_mode,
  input logic       sync_det,
  input logic       byte_vld,
  input logic       fifo_full,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input logic       fifo_wr_en,
  input logic       fill_active,
  input logic       fill_method,
  input logic       overrun,
  input logic       irq1
);
  wire ctl_wr = reg_wr && reg_sel;

  p_no_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> !fifo_full);

  p_cont_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode == 2'b00) |-> (!fifo_wr_en && !irq1));

  p_sync_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_mode == 2'b01 && !fill_method && sync_det && !overrun && !ctl_wr) |=> fill_active);

  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !fill_method && reg_wdata[1]) |=> !fill_active);

  p_ovr_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !fill_active && !fill_method && !ctl_wr) |=> !fill_active);

  p_manual_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_method && !ctl_wr) |=> $stable(fill_active));

  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && fifo_full && data_mode[1] && !(ctl_wr && reg_wdata[2])) |=> overrun);

  p_ovr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[2]) |=> !overrun);
endmodule

bind rx_fifo_fill_ctrl rx_fifo_fill_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_mode(data_mode), .sync_det(sync_det),
  .byte_vld(byte_vld), .fifo_full(fifo_full), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .fifo_wr_en(fifo_wr_en), .fill_active(fill_active),
  .fill_method(fill_method), .overrun(overrun), .irq1(irq1)
);

// File: tb/test_rx_fifo_fill_ctrl.sv
`timescale 1ns/1ps
module test_rx_fifo_fill_ctrl;
  logic clk = 0, rst_n = 0;
  logic [1:0] data_mode = 0;
  logic sync_det = 0, byte_vld = 0, fifo_full = 0, fifo_empty = 1, fifo_thresh = 0;
  logic rssi_evt = 0, payload_rdy = 0, crc_ok = 0, addr_match = 0, addr_filt_en = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, byte_data = 0;
  logic [7:0] reg_rdata, fifo_wr_data;
  logic fifo_wr_en, fifo_flush, fill_active, overrun, irq0, irq1;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_meth, m_fill, m_ovr, m_s0, m_s1;

  always #4 clk = ~clk;

  rx_fifo_fill_ctrl #(.DW(8)) i_rx_fifo_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .data_mode(data_mode), .sync_det(sync_det),
    .byte_vld(byte_vld), .byte_data(byte_data), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_thresh(fifo_thresh), .rssi_evt(rssi_evt),
    .payload_rdy(payload_rdy), .crc_ok(crc_ok), .addr_match(addr_match),
    .addr_filt_en(addr_filt_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_flush(fifo_flush), .fill_active(fill_active),
    .overrun(overrun), .irq0(irq0), .irq1(irq1));

  function automatic bit eligible();
    return byte_vld && (data_mode >= 2 || (data_mode == 1 && m_fill == 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_meth = 0; m_fill = 0; m_ovr = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      int nf, no;
      nf = m_fill; no = m_ovr;
      if (reg_wr && reg_sel) begin
        if (m_meth == 1) nf = reg_wdata[1];
        else if (reg_wdata[1]) nf = 0;
        else if (sync_det && data_mode == 1 && m_ovr == 0) nf = 1;
      end else if (m_meth == 0 && sync_det && data_mode == 1 && m_ovr == 0) nf = 1;
      if (eligible() && fifo_full) no = 1;
      if (reg_wr && reg_sel && reg_wdata[2]) no = 0;
      if (reg_wr && !reg_sel) begin m_s0 = reg_wdata[1:0]; m_s1 = reg_wdata[3:2]; end
      if (reg_wr && reg_sel) m_meth = reg_wdata[0];
      m_fill = nf; m_ovr = no;
    end
  end

  task automatic chk(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int e_wr, e_i0, e_i1, e_rd;
    e_wr = eligible() && !fifo_full;
    e_i0 = 0; e_i1 = 0;
    if (data_mode >= 2) begin
      if (m_s0 == 0) e_i0 = payload_rdy;
      else if (m_s0 == 1) e_i0 = e_wr;
      else if (m_s0 == 2) e_i0 = !fifo_empty;
      else e_i0 = addr_filt_en ? addr_match : sync_det;
      e_i1 = (m_s1 == 0) ? crc_ok : (m_s1 == 1) ? fifo_full : (m_s1 == 2) ? rssi_evt : fifo_thresh;
    end else if (data_mode == 1) begin
      e_i0 = (m_s0 == 1) ? e_wr : (m_s0 == 2) ? !fifo_empty : (m_s0 == 3) ? sync_det : 0;
      e_i1 = (m_s1 == 0) ? 0 : (m_s1 == 1) ? fifo_full : (m_s1 == 2) ? rssi_evt : fifo_thresh;
    end else begin
      e_i0 = (m_s0 == 0) ? 0 : (m_s0 == 2) ? rssi_evt : sync_det;
    end
    if (reg_sel) e_rd = (!fifo_empty) * 16 + fifo_full * 8 + m_ovr * 4 + m_fill * 2 + m_meth;
    else e_rd = m_s1 * 4 + m_s0;
    chk(data_mode == 0 ? "R2" : cur_req, "fifo_wr_en", fifo_wr_en, e_wr);
    if (e_wr) chk("R3", "fifo_wr_data", fifo_wr_data, byte_data);
    chk("R8", "fifo_flush", fifo_flush, rst_n && reg_wr && reg_sel && reg_wdata[2]);
    chk(cur_req, "fill_active", fill_active, m_fill);
    chk(cur_req, "overrun", overrun, m_ovr);
    chk("R9", "reg_rdata", reg_rdata, e_rd);
    chk("R10", "irq0", irq0, e_i0);
    chk("R11", "irq1", irq1, e_i1);
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wreg(bit s, logic [7:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d; cyc(); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic sync1();
    sync_det = 1; cyc(); sync_det = 0;
  endtask

  task automatic bytes(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin byte_vld = 1; byte_data = base + 8'(i * 7); cyc(); end
    byte_vld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    cyc(3); rst_n = 1; cyc(2);

    cur_req = "R9";
    wreg(0, 8'h0E); reg_sel = 0; cyc(); reg_sel = 1; fifo_empty = 0; cyc(); fifo_empty = 1; reg_sel = 0;

    cur_req = "R2";
    data_mode = 0; sync1(); bytes(3, 8'h10); wreg(1, 8'h03); bytes(2, 8'h20); wreg(1, 8'h00);

    cur_req = "R10";
    for (int md = 0; md < 4; md++)
      for (int sc = 0; sc < 16; sc++) begin
        data_mode = 2'(md);
        wreg(0, 8'(sc));
        for (int p = 0; p < 16; p++) begin
          int v;
          v = (p * 37 + sc * 11 + md * 5) & 255;
          {rssi_evt, payload_rdy, crc_ok, addr_match, addr_filt_en, fifo_thresh, fifo_full, fifo_empty} = 8'(v);
          sync_det = p[0];
          cyc();
        end
        sync_det = 0;
        if (md == 1) wreg(1, 8'h02);
      end
    {rssi_evt, payload_rdy, crc_ok, addr_match, addr_filt_en, fifo_thresh, fifo_full} = 0;
    fifo_empty = 1;
    wreg(1, 8'h06);

    cur_req = "R3";
    data_mode = 1; wreg(0, 8'h05); wreg(1, 8'h00);
    bytes(2, 8'h30);
    sync1(); bytes(4, 8'h40);
    cur_req = "R7";
    fifo_full = 1; bytes(1, 8'h55); fifo_full = 0; cyc();
    cur_req = "R5";
    wreg(1, 8'h02); sync1(); bytes(2, 8'h60); cyc();
    cur_req = "R8";
    byte_vld = 1; fifo_full = 1; sync_det = 0;
    wreg(1, 8'h04); byte_vld = 0; fifo_full = 0; cyc();
    sync1(); bytes(2, 8'h70);
    cur_req = "R4";
    sync_det = 1; wreg(1, 8'h02); sync_det = 0; cyc(); bytes(2, 8'h80);
    sync1(); bytes(2, 8'h90);

    cur_req = "R6";
    wreg(1, 8'h01); sync1(); bytes(2, 8'hA0);
    wreg(1, 8'h03); bytes(3, 8'hB0); sync1();
    wreg(1, 8'h01); bytes(2, 8'hC0); sync1(); cyc();
    wreg(1, 8'h00);

    cur_req = "R12";
    data_mode = 2; wreg(1, 8'h02); bytes(4, 8'hD0);
    data_mode = 3; bytes(2, 8'hE0);
    fifo_full = 1; bytes(1, 8'hEE); fifo_full = 0; wreg(1, 8'h04); cyc(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule